// File: doc/BRIEF.md
# Bridge I/O Window Decoder

This block holds the configuration state for two I/O address windows of a bus bridge and decides, for every I/O address presented to it, whether that address falls inside one of the windows. An address that falls inside is forwarded to the downstream card bus. Each window has a base register and a limit register. The base register supplies the 64 KB page and the bottom of the window. The limit register supplies the top of the window inside that same page, in doubleword steps. A window is live only once its base or its limit holds a nonzero value, so nothing is forwarded after reset.

Software reaches the registers through a 32-bit configuration port with per-byte write enables. Read data is registered. The port also carries an 8-bit interrupt line value and one control bit. That control bit selects whether the two low bits of each window register report 16-bit decoding (00) or 32-bit decoding (01). The compare port is purely combinational: one hit bit per window, computed from the I/O address and the stored registers.

Top module: `iowin_decoder`

## Requirements
- R1: After reset, every window register reads 0 and win_hit is 0 for any address.
- R2: Limit bits 15..2 are writable. Limit bits 31..16 always read 0, and writes to them have no effect.
- R3: Bits 1..0 of every base and limit register read 00 while control bit 28 of dword 84h (bit 12 of the 16-bit register at 86h) is 0, and 01 while it is 1. Writes to bits 1..0 have no effect.
- R4: A write changes only the byte lanes whose cfg_be bit is set. Lane n is bits 8n+7..8n.
- R5: A window can hit only while its base register (bits 31..2) or its limit register (bits 15..2) is nonzero.
- R6: Window n hits when io_addr[31:16] equals base[31:16] and base[15:2] <= io_addr[15:2] <= limit[15:2]. Both ends are inclusive. The two low address bits are ignored, so the limit acts as if its bits 1..0 were 11.
- R7: Window 0 (base 2Ch, limit 30h) drives win_hit[0] and window 1 (base 34h, limit 38h) drives win_hit[1]. The two windows are independent.
- R8: The interrupt line register in byte 0 of dword 3Ch is fully read/write, resets to FFh, and the other bytes of that dword read 0.
- R9: Reads of any offset other than 2Ch, 30h, 34h, 38h, 3Ch and 84h return 0, and writes to them change nothing.
- R10: A write takes effect at the clock edge that samples cfg_wr. cfg_rdata updates at the edge that samples cfg_rd and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 8 | Byte offset of the configuration dword (bits 1..0 ignored) |
| cfg_be | input | 4 | Byte lane write enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| io_addr | input | 32 | I/O address to classify |
| win_hit | output | 2 | Per-window hit, bit n for window n |

## Verification
Each result has its own latency. A write is visible one clock edge after the strobe. Read data appears at the edge that samples cfg_rd. The hit outputs follow io_addr within the same cycle. The bench drives every input on the falling edge. It samples read data on the falling edge after the read strobe. It samples hits 1 ns after it changes io_addr. A directed test checks the hit output both just before and just after the edge that commits a write, so an extra or missing register stage shows up as a failure.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  // Byte offsets of the configuration dwords; window n sits 8 bytes after window n-1
  localparam int BASE_OFF0 = 'h2C;
  localparam int LIM_OFF0  = 'h30;
  localparam int WIN_STEP  = 8;
  localparam int IRQ_OFF   = 'h3C;
  localparam int CTRL_OFF  = 'h84;
  // Position of the width-select bit inside the control dword (bit 12 of offset 86h)
  localparam int SEL_BIT   = 28;

  function automatic int base_word(input int n);
    return (BASE_OFF0 + WIN_STEP * n) / 4;
  endfunction

  function automatic int lim_word(input int n);
    return (LIM_OFF0 + WIN_STEP * n) / 4;
  endfunction

  // Low-bit decoding indicator: 00 = 16-bit, 01 = 32-bit
  function automatic logic [1:0] width_ind(input logic sel);
    return {1'b0, sel};
  endfunction
endpackage

// File: rtl/iowin_cfg_regs.sv
module iowin_cfg_regs
  import iowin_pkg::*;
#(
  parameter int CFG_AW    = 8,
  parameter int NUM_WIN   = 2,
  parameter logic [7:0] IRQ_RESET = 8'hFF,
  localparam int WORD_W   = CFG_AW - 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_wr,
  input  logic                     cfg_rd,
  input  logic [CFG_AW-1:0]        cfg_addr,
  input  logic [3:0]               cfg_be,
  input  logic [31:0]              cfg_wdata,
  output logic [31:0]              cfg_rdata,
  output logic [NUM_WIN-1:0][29:0] base_q,
  output logic [NUM_WIN-1:0][13:0] lim_q
);
  logic [WORD_W-1:0] widx;
  logic [7:0]        irq_q;
  logic              sel_q;
  logic [31:0]       rd_next;

  assign widx = cfg_addr[CFG_AW-1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      lim_q  <= '0;
      irq_q  <= IRQ_RESET;
      sel_q  <= 1'b0;
    end else if (cfg_wr) begin
      for (int n = 0; n < NUM_WIN; n++) begin
        if (widx == WORD_W'(base_word(n))) begin
          if (cfg_be[0]) base_q[n][5:0]   <= cfg_wdata[7:2];
          if (cfg_be[1]) base_q[n][13:6]  <= cfg_wdata[15:8];
          if (cfg_be[2]) base_q[n][21:14] <= cfg_wdata[23:16];
          if (cfg_be[3]) base_q[n][29:22] <= cfg_wdata[31:24];
        end
        if (widx == WORD_W'(lim_word(n))) begin
          if (cfg_be[0]) lim_q[n][5:0]  <= cfg_wdata[7:2];
          if (cfg_be[1]) lim_q[n][13:6] <= cfg_wdata[15:8];
        end
      end
      if (widx == WORD_W'(IRQ_OFF / 4) && cfg_be[0]) irq_q <= cfg_wdata[7:0];
      if (widx == WORD_W'(CTRL_OFF / 4) && cfg_be[SEL_BIT / 8]) sel_q <= cfg_wdata[SEL_BIT];
    end
  end

  always_comb begin
    rd_next = '0;
    for (int n = 0; n < NUM_WIN; n++) begin
      if (widx == WORD_W'(base_word(n))) rd_next = {base_q[n], width_ind(sel_q)};
      if (widx == WORD_W'(lim_word(n)))  rd_next = {16'h0000, lim_q[n], width_ind(sel_q)};
    end
    if (widx == WORD_W'(IRQ_OFF / 4))  rd_next = {24'h0, irq_q};
    if (widx == WORD_W'(CTRL_OFF / 4)) rd_next[SEL_BIT] = sel_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= rd_next;
  end
endmodule

// File: rtl/iowin_window_cmp.sv
module iowin_window_cmp (
  input  logic [29:0] base,
  input  logic [13:0] lim,
  input  logic [31:0] io_addr,
  output logic        hit
);
  logic live, page_eq, above_lo, below_hi;

  assign live     = (|base) || (|lim);
  assign page_eq  = io_addr[31:16] == base[29:14];
  assign above_lo = io_addr[15:2] >= base[13:0];
  assign below_hi = io_addr[15:2] <= lim;
  assign hit      = live && page_eq && above_lo && below_hi;
endmodule

// File: rtl/iowin_decoder.sv
module iowin_decoder #(
  parameter int CFG_AW  = 8,
  parameter int NUM_WIN = 2,
  parameter logic [7:0] IRQ_RESET = 8'hFF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic               cfg_rd,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [3:0]         cfg_be,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic [31:0]        io_addr,
  output logic [NUM_WIN-1:0] win_hit
);
  logic [NUM_WIN-1:0][29:0] base_q;
  logic [NUM_WIN-1:0][13:0] lim_q;

  iowin_cfg_regs #(
    .CFG_AW(CFG_AW), .NUM_WIN(NUM_WIN), .IRQ_RESET(IRQ_RESET)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .base_q(base_q), .lim_q(lim_q)
  );

  for (genvar n = 0; n < NUM_WIN; n++) begin : g_win
    iowin_window_cmp u_cmp (
      .base(base_q[n]), .lim(lim_q[n]), .io_addr(io_addr), .hit(win_hit[n])
    );
  end
endmodule

// File: rtl/iowin_decoder_chk.sv
module iowin_decoder_chk #(
  parameter int CFG_AW  = 8,
  parameter int NUM_WIN = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_rd,
  input logic [CFG_AW-1:0]  cfg_addr,
  input logic [31:0]        cfg_rdata,
  input logic [NUM_WIN-1:0] win_hit
);
  function automatic logic is_lim(input logic [CFG_AW-1:0] a);
    logic r = 1'b0;
    for (int n = 0; n < NUM_WIN; n++)
      if (a[CFG_AW-1:2] == (CFG_AW-2)'(('h30 + 8 * n) >> 2)) r = 1'b1;
    return r;
  endfunction

  function automatic logic is_win(input logic [CFG_AW-1:0] a);
    logic r = is_lim(a);
    for (int n = 0; n < NUM_WIN; n++)
      if (a[CFG_AW-1:2] == (CFG_AW-2)'(('h2C + 8 * n) >> 2)) r = 1'b1;
    return r;
  endfunction

  function automatic logic is_known(input logic [CFG_AW-1:0] a);
    return is_win(a) || a[CFG_AW-1:2] == (CFG_AW-2)'('h3C >> 2)
                     || a[CFG_AW-1:2] == (CFG_AW-2)'('h84 >> 2);
  endfunction

  // R2: the page half of a limit read is always zero
  p_lim_page_zero_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_rd) && is_lim($past(cfg_addr))) |-> cfg_rdata[31:16] == 16'h0);

  // R3: the indicator never reads 1x
  p_ind_bit1_zero_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_rd) && is_win($past(cfg_addr))) |-> !cfg_rdata[1]);

  // R1 / R5: right after reset no window is live
  p_no_hit_after_rst_r5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> win_hit == '0);

  // R9: unimplemented offsets read zero
  p_unimpl_zero_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_rd) && !is_known($past(cfg_addr))) |-> cfg_rdata == 32'h0);

  // R10: read data holds without a read strobe
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_rd) |-> $stable(cfg_rdata));
endmodule

bind iowin_decoder iowin_decoder_chk #(.CFG_AW(CFG_AW), .NUM_WIN(NUM_WIN)) u_chk (
  .clk(clk), .rst(rst), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
  .cfg_rdata(cfg_rdata), .win_hit(win_hit)
);

// File: tb/test_iowin_decoder.sv
module test_iowin_decoder;
  localparam int NUM_WIN = 2;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_HIT = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  req;
    logic [7:0]  addr;
    logic [3:0]  be;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 39;
  localparam vec_t VEC [NV] = '{
    '{OP_RD,  4'd1, 8'h30, 4'h0, 32'h0,        32'h0},        // R1
    '{OP_RD,  4'd1, 8'h38, 4'h0, 32'h0,        32'h0},        // R1
    '{OP_RD,  4'd8, 8'h3C, 4'h0, 32'h0,        32'h000000FF}, // R8
    '{OP_HIT, 4'd5, 8'h00, 4'h0, 32'h0,        32'h0},        // R5
    '{OP_WR,  4'd2, 8'h30, 4'hF, 32'hFFFFFFFF, 32'h0},        // R2
    '{OP_RD,  4'd2, 8'h30, 4'h0, 32'h0,        32'h0000FFFC}, // R2
    '{OP_WR,  4'd4, 8'h30, 4'h1, 32'h0,        32'h0},        // R4
    '{OP_RD,  4'd4, 8'h30, 4'h0, 32'h0,        32'h0000FF00}, // R4
    '{OP_WR,  4'd6, 8'h2C, 4'hF, 32'h12340100, 32'h0},        // R6
    '{OP_WR,  4'd6, 8'h30, 4'hF, 32'h000001FF, 32'h0},        // R6
    '{OP_HIT, 4'd6, 8'h00, 4'h0, 32'h12340100, 32'h1},        // R6 lower edge
    '{OP_HIT, 4'd6, 8'h00, 4'h0, 32'h12340103, 32'h1},        // R6 low bits ignored
    '{OP_HIT, 4'd6, 8'h00, 4'h0, 32'h123401FF, 32'h1},        // R6 upper edge
    '{OP_HIT, 4'd6, 8'h00, 4'h0, 32'h12340200, 32'h0},        // R6 above
    '{OP_HIT, 4'd6, 8'h00, 4'h0, 32'h123400FC, 32'h0},        // R6 below
    '{OP_HIT, 4'd6, 8'h00, 4'h0, 32'h12350150, 32'h0},        // R6 other page
    '{OP_WR,  4'd3, 8'h84, 4'h8, 32'h10000000, 32'h0},        // R3
    '{OP_RD,  4'd3, 8'h30, 4'h0, 32'h0,        32'h000001FD}, // R3
    '{OP_RD,  4'd3, 8'h2C, 4'h0, 32'h0,        32'h12340101}, // R3
    '{OP_RD,  4'd3, 8'h84, 4'h0, 32'h0,        32'h10000000}, // R3
    '{OP_WR,  4'd4, 8'h84, 4'h7, 32'h0,        32'h0},        // R4
    '{OP_RD,  4'd4, 8'h30, 4'h0, 32'h0,        32'h000001FD}, // R4
    '{OP_WR,  4'd3, 8'h84, 4'h8, 32'h0,        32'h0},        // R3
    '{OP_WR,  4'd3, 8'h30, 4'h1, 32'h000000FF, 32'h0},        // R3 low bits RO
    '{OP_RD,  4'd3, 8'h30, 4'h0, 32'h0,        32'h000001FC}, // R3
    '{OP_WR,  4'd7, 8'h38, 4'h3, 32'h00000010, 32'h0},        // R7
    '{OP_HIT, 4'd7, 8'h00, 4'h0, 32'h00000000, 32'h2},        // R7
    '{OP_HIT, 4'd7, 8'h00, 4'h0, 32'h00000013, 32'h2},        // R7
    '{OP_HIT, 4'd7, 8'h00, 4'h0, 32'h00000014, 32'h0},        // R7
    '{OP_HIT, 4'd7, 8'h00, 4'h0, 32'h12340150, 32'h1},        // R7
    '{OP_WR,  4'd8, 8'h3C, 4'h1, 32'h0000005A, 32'h0},        // R8
    '{OP_RD,  4'd8, 8'h3C, 4'h0, 32'h0,        32'h0000005A}, // R8
    '{OP_WR,  4'd4, 8'h3C, 4'hE, 32'hFFFFFF00, 32'h0},        // R4
    '{OP_RD,  4'd4, 8'h3C, 4'h0, 32'h0,        32'h0000005A}, // R4
    '{OP_WR,  4'd9, 8'h40, 4'hF, 32'hFFFFFFFF, 32'h0},        // R9
    '{OP_RD,  4'd9, 8'h40, 4'h0, 32'h0,        32'h0},        // R9
    '{OP_RD,  4'd9, 8'h00, 4'h0, 32'h0,        32'h0},        // R9
    '{OP_WR,  4'd5, 8'h38, 4'h3, 32'h0,        32'h0},        // R5
    '{OP_HIT, 4'd5, 8'h00, 4'h0, 32'h00000000, 32'h0}         // R5
  };

  logic clk = 1'b0, rst = 1'b1, cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [3:0] cfg_be = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata, io_addr = '0;
  logic [NUM_WIN-1:0] win_hit;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  iowin_decoder i_iowin_decoder (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .io_addr(io_addr), .win_hit(win_hit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic probe(input logic [31:0] a, output logic [31:0] h);
    @(negedge clk);
    io_addr = a;
    #1 h = 32'(win_hit);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_WR: do_wr(VEC[i].addr, VEC[i].be, VEC[i].data);
        OP_RD: begin
          do_rd(VEC[i].addr, r);
          check($sformatf("R%0d vec%0d read", VEC[i].req, i), r, VEC[i].exp);
        end
        default: begin
          probe(VEC[i].data, r);
          check($sformatf("R%0d vec%0d hit", VEC[i].req, i), r, VEC[i].exp);
        end
      endcase
    end

    // R10: write commits at the strobe edge, not before
    probe(32'h00000008, r);
    check("R10 before write", r, 32'h0);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 8'h38; cfg_be = 4'h1; cfg_wdata = 32'h0000000C;
    #1 check("R10 strobe not yet committed", 32'(win_hit), 32'h0);
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
    check("R10 committed after edge", 32'(win_hit), 32'h2);

    // R10: read data holds while no read strobe
    do_rd(8'h3C, r);
    @(negedge clk);
    cfg_addr = 8'h30;
    repeat (3) @(negedge clk);
    check("R10 rdata hold", cfg_rdata, 32'h0000005A);

    // R1 / R8: defaults return after reset
    apply_reset();
    probe(32'h12340150, r);
    check("R1 no hit after reset", r, 32'h0);
    do_rd(8'h2C, r); check("R1 base0 reset", r, 32'h0);
    do_rd(8'h38, r); check("R1 limit1 reset", r, 32'h0);
    do_rd(8'h84, r); check("R3 ctrl reset", r, 32'h0);
    do_rd(8'h3C, r); check("R8 irq reset", r, 32'h000000FF);

    // R5: a nonzero base alone enables a window (limit 0 → single-dword page bottom only if base low is 0)
    do_wr(8'h34, 4'h8, 32'h01000000);
    probe(32'h01000000, r); check("R5 base-only enable", r, 32'h2);
    probe(32'h01000004, r); check("R5 base-only above limit", r, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule